// File: doc/BRIEF.md
# Asynchronous Serial Transmit Channel

This block is a byte-wide serial transmitter that a processor drives through a small register bus. Software, or a DMA-style master, places a byte in a holding register. The byte is then copied into a shift register and sent as one frame with a low start bit, the data bits least significant first, and a high stop bit. Each bit lasts a fixed number of baud ticks. The baud ticks come from outside the block.

Two status flags report progress. The holding-empty flag is set when the holding register may take a new byte. The finished flag is set when the shifter has run dry. The holding-empty flag also drives an interrupt request while the transmitter is enabled.

When the transmitter is first switched on, it sends a full frame time of idle marks before any data can leave. The output pin can be handed to a general-purpose port bit. Driving that bit low produces a break.

Top module: `async_tx_chan`

## Requirements
- R1: After reset, the holding-empty flag and the finished flag are both 1, the enable bit is 0, the port bit is 1, the pin selector is 0, `txd` is 1 and `tx_irq` is 0.
- R2: The register addresses and fields are as follows.
  - Address 0 is the holding register.
  - Address 1 holds the enable bit in bit 0.
  - Address 2 is status, with holding-empty in bit 0 and finished in bit 1.
  - Address 3 holds the port bit in bit 0 and the pin selector in bit 1.
  - `bus_rdata` shows the addressed register while `bus_rd` is high.
- R3: When enable goes from 0 to 1, `txd` stays 1 for (DATA_BITS+2)*TICKS_PER_BIT baud ticks. No byte is loaded during that time, and setting enable alone never starts a frame.
- R4: A processor write of 0 to status bit 0 commits the held byte by clearing holding-empty. It does so only if status was read with holding-empty equal to 1 since the last commit. Otherwise the write is ignored and the flag stays 1.
- R5: A write to the holding register with `bus_dma` high commits the byte at once, with no status access.
- R6: A frame is a 0 start bit, then the DATA_BITS data bits with the least significant bit first, then a 1 stop bit. Each bit lasts TICKS_PER_BIT baud ticks, starting from the tick that loads the byte.
- R7: A committed byte is loaded into the shifter on a baud tick when the shifter is idle and no idle preamble is running. The load sets holding-empty back to 1.
- R8: The finished flag is set on the last tick of a stop bit if holding-empty is 1 at that moment. A commit clears it.
- R9: If a byte is committed before the current stop bit ends, its start bit begins on that same last tick, with no idle gap.
- R10: `tx_irq` is high exactly when enable is 1 and holding-empty is 1.
- R11: Clearing enable in the middle of a frame stops shifting. From the next cycle, the transmitter output is 1.
- R12: With the pin selector at 1, `txd` follows the port bit. With the selector at 0, `txd` follows the transmitter. A port bit of 0 with the selector at 1 holds the line low (a break).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_dma | input | 1 | Marks a write as coming from the DMA master |
| bus_wdata | input | DATA_BITS | Write data |
| bus_rdata | output | DATA_BITS | Read data |
| baud_tick | input | 1 | One-cycle baud tick |
| txd | output | 1 | Serial output pin |
| tx_irq | output | 1 | Holding-empty interrupt request |

## Verification
The bench builds the block with DATA_BITS = 8 and TICKS_PER_BIT = 4. This keeps the idle preamble to 40 ticks and a frame to 40 ticks. At that size, every bit of several whole frames can be compared tick by tick. It also reaches the back-to-back hand-over at the stop boundary, a disable in the middle of a data bit, and a break through the port bit. The byte patterns 0xA5, 0x3C, 0x81 and 0x00 give alternating bits, runs of bits, and set first and last bits.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef enum logic [1:0] {
    A_HOLD = 2'd0,
    A_CTRL = 2'd1,
    A_STAT = 2'd2,
    A_PORT = 2'd3
  } reg_addr_e;

  // Baud ticks in one whole frame: start + data + stop.
  function automatic int frame_ticks(input int data_bits, input int ticks_per_bit);
    return (data_bits + 2) * ticks_per_bit;
  endfunction

endpackage

// File: rtl/tx_regs.sv
module tx_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_dma,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          load_evt,
  input  logic          frame_end,
  output logic [DW-1:0] hold_q,
  output logic          tx_en,
  output logic          port_dat,
  output logic          port_sel,
  output logic          empty,
  output logic          done,
  output logic          commit_evt,
  output logic          irq
);
  import async_tx_pkg::*;

  logic armed;
  logic wr_hold, wr_ctrl, wr_stat, wr_port;
  logic dma_commit, cpu_commit, arm_evt;

  assign wr_hold    = bus_wr && (bus_addr == A_HOLD);
  assign wr_ctrl    = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat    = bus_wr && (bus_addr == A_STAT);
  assign wr_port    = bus_wr && (bus_addr == A_PORT);
  assign dma_commit = wr_hold && bus_dma;
  assign cpu_commit = wr_stat && !bus_wdata[0] && armed && empty;
  assign commit_evt = dma_commit || cpu_commit;
  assign arm_evt    = bus_rd && (bus_addr == A_STAT) && empty;
  assign irq        = tx_en && empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      tx_en    <= 1'b0;
      port_dat <= 1'b1;
      port_sel <= 1'b0;
      empty    <= 1'b1;
      done     <= 1'b1;
      armed    <= 1'b0;
    end else begin
      if (wr_hold) hold_q <= bus_wdata;
      if (wr_ctrl) tx_en <= bus_wdata[0];
      if (wr_port) begin
        port_dat <= bus_wdata[0];
        port_sel <= bus_wdata[1];
      end
      if (commit_evt)    empty <= 1'b0;
      else if (load_evt) empty <= 1'b1;
      if (commit_evt)    armed <= 1'b0;
      else if (arm_evt)  armed <= 1'b1;
      if (commit_evt)                done <= 1'b0;
      else if (frame_end && empty)   done <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_HOLD: bus_rdata = hold_q;
        A_CTRL: bus_rdata[0] = tx_en;
        A_STAT: bus_rdata[1:0] = {done, empty};
        default: bus_rdata[1:0] = {port_sel, port_dat};
      endcase
    end
  end
endmodule

// File: rtl/tx_frame.sv
module tx_frame #(
  parameter int DW  = 8,
  parameter int TPB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          baud_tick,
  input  logic          empty,
  input  logic [DW-1:0] hold_q,
  output logic          ser_out,
  output logic          load_evt,
  output logic          frame_end,
  output logic          pre_active
);
  localparam int NBITS  = DW + 2;
  localparam int FRAME  = async_tx_pkg::frame_ticks(DW, TPB);
  localparam int IDX_W  = $clog2(NBITS);
  localparam int TCK_W  = (TPB > 1) ? $clog2(TPB) : 1;
  localparam int PRE_W  = $clog2(FRAME + 1);

  logic             en_q, busy;
  logic [PRE_W-1:0] pre_cnt;
  logic [TCK_W-1:0] tick_cnt;
  logic [IDX_W-1:0] bit_idx;
  logic [DW-1:0]    shreg;
  logic             en_rise, bit_last_tick;

  function automatic logic frame_bit(input logic [DW-1:0] sh, input logic [IDX_W-1:0] idx);
    logic [NBITS-1:0] f;
    f = {1'b1, sh, 1'b0};
    return f[idx];
  endfunction

  assign en_rise       = en && !en_q;
  assign pre_active    = (pre_cnt != '0);
  assign bit_last_tick = en && busy && baud_tick && (tick_cnt == TCK_W'(TPB - 1));
  assign frame_end     = bit_last_tick && (bit_idx == IDX_W'(NBITS - 1));
  assign load_evt      = en && !en_rise && baud_tick && !pre_active && !empty &&
                         (!busy || frame_end);
  assign ser_out       = (en && busy) ? frame_bit(shreg, bit_idx) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pre_cnt  <= '0;
      busy     <= 1'b0;
      tick_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
    end else begin
      en_q <= en;
      if (!en)                          pre_cnt <= '0;
      else if (en_rise)                 pre_cnt <= PRE_W'(FRAME);
      else if (baud_tick && pre_active) pre_cnt <= pre_cnt - 1'b1;

      if (!en) begin
        busy <= 1'b0;
      end else if (load_evt) begin
        busy     <= 1'b1;
        shreg    <= hold_q;
        bit_idx  <= '0;
        tick_cnt <= '0;
      end else if (frame_end) begin
        busy <= 1'b0;
      end else if (busy && baud_tick) begin
        if (bit_last_tick) begin
          tick_cnt <= '0;
          bit_idx  <= bit_idx + 1'b1;
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tx_pinmux.sv
module tx_pinmux (
  input  logic ser_out,
  input  logic port_dat,
  input  logic port_sel,
  output logic pin
);
  assign pin = port_sel ? port_dat : ser_out;
endmodule

// File: rtl/async_tx_chan.sv
module async_tx_chan #(
  parameter int DATA_BITS     = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic                 bus_dma,
  input  logic [DATA_BITS-1:0] bus_wdata,
  output logic [DATA_BITS-1:0] bus_rdata,
  input  logic                 baud_tick,
  output logic                 txd,
  output logic                 tx_irq
);
  logic [DATA_BITS-1:0] hold_q;
  logic tx_en, port_dat, port_sel, empty, done, commit_evt;
  logic ser_out, load_evt, frame_end, pre_active;

  tx_regs #(.DW(DATA_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_dma(bus_dma), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .load_evt(load_evt), .frame_end(frame_end),
    .hold_q(hold_q), .tx_en(tx_en), .port_dat(port_dat), .port_sel(port_sel),
    .empty(empty), .done(done), .commit_evt(commit_evt), .irq(tx_irq)
  );

  tx_frame #(.DW(DATA_BITS), .TPB(TICKS_PER_BIT)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .baud_tick(baud_tick),
    .empty(empty), .hold_q(hold_q), .ser_out(ser_out), .load_evt(load_evt),
    .frame_end(frame_end), .pre_active(pre_active)
  );

  tx_pinmux u_mux (
    .ser_out(ser_out), .port_dat(port_dat), .port_sel(port_sel), .pin(txd)
  );
endmodule

// File: rtl/async_tx_chan_chk.sv
module async_tx_chan_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic tx_irq,
  input logic tx_en,
  input logic empty,
  input logic done,
  input logic port_sel,
  input logic port_dat,
  input logic load_evt,
  input logic frame_end,
  input logic pre_active,
  input logic commit_evt
);
  p_idle_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !port_sel) |-> txd);

  p_no_load_preamble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_active |-> !load_evt);

  p_load_refills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !commit_evt) |=> empty);

  p_empty_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty) |-> $past(commit_evt));

  p_end_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && empty && !commit_evt) |=> done);

  p_commit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (!done && !empty));

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && empty) |-> tx_irq);

  p_break_r12: assert property (@(posedge clk) disable iff (!rst_n)
    port_sel |-> (txd == port_dat));
endmodule

bind async_tx_chan async_tx_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_irq(tx_irq), .tx_en(tx_en),
  .empty(empty), .done(done), .port_sel(port_sel), .port_dat(port_dat),
  .load_evt(load_evt), .frame_end(frame_end), .pre_active(pre_active),
  .commit_evt(commit_evt)
);

// File: tb/async_tx_chan_tb.sv
`timescale 1ns/1ps
module async_tx_chan_tb;
  localparam int DW  = 8;
  localparam int TPB = 4;
  localparam int FR  = (DW + 2) * TPB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_dma = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          baud_tick = 1'b0;
  logic          txd, tx_irq;
  int            n_checks = 0, n_errs = 0;

  always #10 clk = ~clk;

  async_tx_chan #(.DATA_BITS(DW), .TICKS_PER_BIT(TPB)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_dma(bus_dma), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .baud_tick(baud_tick), .txd(txd), .tx_irq(tx_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d, input logic dma);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_dma = dma; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_dma = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk); baud_tick = 1'b1;
    @(negedge clk); baud_tick = 1'b0;
  endtask

  function automatic logic fbit(input logic [DW-1:0] b, input int k);
    if (k == 0) return 1'b0;
    if (k <= DW) return b[k-1];
    return 1'b1;
  endfunction

  // Called right after the load tick; issues FR ticks, checking each bit.
  task automatic run_frame(input logic [DW-1:0] b);
    for (int i = 0; i < FR; i++) begin
      check("R6 frame bit", {31'd0, txd}, {31'd0, fbit(b, i / TPB)});
      tick_once();
    end
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 txd idle", {31'd0, txd}, 32'd1);
    check("R1 irq low", {31'd0, tx_irq}, 32'd0);
    bus_read(2'd1, d); check("R1 enable", {24'd0, d}, 32'd0);
    bus_read(2'd3, d); check("R1 port", {24'd0, d}, 32'd1);
  endtask

  task automatic t_unarmed_clear();
    logic [DW-1:0] d;
    bus_write(2'd2, 8'h00, 1'b0);
    bus_read(2'd2, d);
    check("R4 unarmed clear ignored, R1 flags", {24'd0, d}, 32'd3);
  endtask

  task automatic t_cpu_send();
    logic [DW-1:0] d;
    bus_write(2'd1, 8'h01, 1'b0);
    check("R10 irq with enable", {31'd0, tx_irq}, 32'd1);
    bus_read(2'd2, d);
    bus_write(2'd0, 8'hA5, 1'b0);
    bus_read(2'd0, d); check("R2 hold readback", {24'd0, d}, 32'hA5);
    bus_write(2'd2, 8'h00, 1'b0);
    bus_read(2'd2, d); check("R4 armed commit", {24'd0, d}, 32'd0);
    check("R10 irq low", {31'd0, tx_irq}, 32'd0);
    for (int i = 0; i < FR; i++) begin
      tick_once();
      check("R3 preamble mark", {31'd0, txd}, 32'd1);
    end
    bus_read(2'd2, d); check("R3 no load in preamble", {24'd0, d}, 32'd0);
    tick_once();
    bus_read(2'd2, d); check("R7 load refills", {24'd0, d}, 32'd1);
    check("R10 irq after load", {31'd0, tx_irq}, 32'd1);
    run_frame(8'hA5);
    bus_read(2'd2, d); check("R8 finished set", {24'd0, d}, 32'd3);
  endtask

  task automatic t_dma_b2b();
    logic [DW-1:0] d;
    bus_write(2'd0, 8'h3C, 1'b1);
    bus_read(2'd2, d); check("R5 dma commit", {24'd0, d}, 32'd0);
    tick_once();
    bus_write(2'd0, 8'h81, 1'b1);
    run_frame(8'h3C);
    bus_read(2'd2, d); check("R9 back to back load", {24'd0, d}, 32'd1);
    run_frame(8'h81);
    check("R9 idle after", {31'd0, txd}, 32'd1);
    bus_read(2'd2, d); check("R8 finished after pair", {24'd0, d}, 32'd3);
  endtask

  task automatic t_disable_mid();
    bus_write(2'd0, 8'h00, 1'b1);
    tick_once();
    for (int i = 0; i < TPB + 2; i++) tick_once();
    check("R11 in data bit", {31'd0, txd}, 32'd0);
    bus_write(2'd1, 8'h00, 1'b0);
    check("R11 idle after disable", {31'd0, txd}, 32'd1);
    tick_once();
    check("R11 stays idle", {31'd0, txd}, 32'd1);
    check("R10 irq off when disabled", {31'd0, tx_irq}, 32'd0);
  endtask

  task automatic t_break();
    bus_write(2'd3, 8'h00, 1'b0);
    check("R12 selector off", {31'd0, txd}, 32'd1);
    bus_write(2'd3, 8'h02, 1'b0);
    check("R12 break low", {31'd0, txd}, 32'd0);
    bus_write(2'd3, 8'h03, 1'b0);
    check("R12 port high", {31'd0, txd}, 32'd1);
    bus_write(2'd3, 8'h01, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unarmed_clear();
    t_cpu_send();
    t_dma_b2b();
    t_disable_mid();
    t_break();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_errs++; n_checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule